// File: doc/BRIEF.md
# DMA Channel Control and Status Register Block

This block is the register front end for a single descriptor-chained DMA channel. Software reaches it over a simple 32-bit register bus with separate write and read strobes. It holds the channel enable, a self-clearing request that tells the engine to fetch the next-descriptor pointer again, and the next-descriptor pointer itself. It also reflects the engine's busy state and the address of the descriptor currently being processed.

Completion, end-of-chain and fault pulses from the channel engine are caught in sticky status flags. Software clears each flag by writing a one to its bit. An interrupt line is raised while any of these flags is set. The descriptor engine sits outside the block and only connects to its engine-side ports.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, enable, append, all sticky flags, the next-descriptor pointer, the read data and the interrupt are all zero.
- R2: A write to the control register (offset 0x00) loads bit 0 into the channel enable, and the enable drives `eng_enable` from the next cycle.
- R3: Writing 1 to control bit 1 sets the append request. The request stays set, and reads back as 1, until a clock edge samples `eng_append_ack`; it is clear after that edge. Writing 0 to bit 1 has no effect. If a write of 1 and an acknowledge meet at the same edge, the request stays set.
- R4: Status (offset 0x04) bit 13 reads as the level of `eng_busy`. Writes to bit 13 have no effect.
- R5: Status bit 12 (transfer done, from `evt_xfer_done`) and bit 11 (end of chain, from `evt_chain_end`) are set by their event pulse. They hold until software writes 1 to that bit of the status register, and writing 0 leaves them set.
- R6: Fault flags are sticky and write-1-to-clear at these positions: `evt_fault[0]` sets status bit 3, `evt_fault[1]` sets bit 4, `evt_fault[2]` sets bit 5 and `evt_fault[3]` sets bit 9.
- R7: When an event pulse and a write-1-to-clear of the same flag meet at the same edge, the flag stays set.
- R8: Offset 0x08 reads the value on `eng_cur_desc`. Writes to it have no effect.
- R9: Offset 0x24 is a read/write next-descriptor pointer. It drives `eng_next_desc` from the cycle after the write.
- R10: `irq` is high exactly when at least one sticky status flag is set.
- R11: Read data appears on `reg_rdata` in the cycle after `reg_rd` and holds while no read is issued. Unmapped offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| eng_enable | output | 1 | Channel enable to the engine |
| eng_append_req | output | 1 | Append request to the engine |
| eng_append_ack | input | 1 | Engine has taken the append request |
| eng_busy | input | 1 | Engine is working on a descriptor |
| eng_cur_desc | input | 32 | Address of the descriptor in progress |
| eng_next_desc | output | 32 | Next-descriptor pointer |
| evt_xfer_done | input | 1 | Transfer-done pulse |
| evt_chain_end | input | 1 | End-of-chain pulse |
| evt_fault | input | 4 | Fault pulses: master abort, target abort, memory abort, parity |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the engine raises `eng_append_ack` only as a single-cycle response. They also assume that events are pulses sampled at the clock edge, and that software strobes are valid only on the edge where they are high. Acknowledges raised while no request is pending are treated as harmless, not as protocol errors. The random stimulus drives every input one cycle at a time. It gives acknowledges mostly while a request is pending, with occasional stray ones. It also forces the collisions directly: ack against set, and event against clear.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
   localparam int OFS_CTRL = 'h00;
   localparam int OFS_STAT = 'h04;
   localparam int OFS_CUR  = 'h08;
   localparam int OFS_NEXT = 'h24;

   localparam int BIT_ENABLE = 0;
   localparam int BIT_APPEND = 1;
   localparam int BIT_BUSY   = 13;

   // sticky flag order: done, chain end, fault[0..3]
   localparam int STICKY_N = 6;

   function automatic int sticky_pos(input int idx);
      case (idx)
         0:       return 12;
         1:       return 11;
         2:       return 3;
         3:       return 4;
         4:       return 5;
         default: return 9;
      endcase
   endfunction

   typedef struct packed {
      logic append;
      logic enable;
   } ctrl_t;
endpackage

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_ctrl,
   input  logic wdata_en,
   input  logic wdata_app,
   input  logic app_ack,
   output dma_regs_pkg::ctrl_t ctrl
);
   logic set_app;
   assign set_app = wr_ctrl & wdata_app;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else begin
         if (wr_ctrl)
            ctrl.enable <= wdata_en;
         if (set_app)
            ctrl.append <= 1'b1;
         else if (app_ack)
            ctrl.append <= 1'b0;
      end
   end

   p_enable_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> ctrl.enable == $past(wdata_en));
   p_append_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.append && !app_ack |=> ctrl.append);
   p_append_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.append && app_ack && !set_app |=> !ctrl.append);
   p_append_win_r3: assert property (@(posedge clk) disable iff (!rst_n)
      set_app |=> ctrl.append);
endmodule

// File: rtl/dma_sticky_status.sv
module dma_sticky_status #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flags
);
   initial begin
      if (N < 1) $error("sticky status needs at least one flag");
   end

   for (genvar i = 0; i < N; i++) begin : g_cell
      always_ff @(posedge clk) begin
         if (!rst_n)
            flags[i] <= 1'b0;
         else if (evt[i])
            flags[i] <= 1'b1;
         else if (clr[i])
            flags[i] <= 1'b0;
      end

      p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> flags[i]);
      p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
         flags[i] && !clr[i] |=> flags[i]);
      p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
         clr[i] && !evt[i] |=> !flags[i]);
   end
endmodule

// File: rtl/dma_read_mux.sv
module dma_read_mux #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 6,
   parameter int DESC_W   = 32,
   parameter bit READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] ctrl_word,
   input  logic [DATA_W-1:0] stat_word,
   input  logic [DESC_W-1:0] cur_desc,
   input  logic [DESC_W-1:0] next_desc,
   output logic [DATA_W-1:0] rdata
);
   import dma_regs_pkg::*;

   logic [DATA_W-1:0] sel;

   always_comb begin
      sel = '0;
      if (addr == ADDR_W'(OFS_CTRL))      sel = ctrl_word;
      else if (addr == ADDR_W'(OFS_STAT)) sel = stat_word;
      else if (addr == ADDR_W'(OFS_CUR))  sel = DATA_W'(cur_desc);
      else if (addr == ADDR_W'(OFS_NEXT)) sel = DATA_W'(next_desc);
   end

   if (READ_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            rdata <= '0;
         else if (rd)
            rdata <= sel;
      end

      p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
         !rd |=> $stable(rdata));
   end else begin : g_comb
      logic unused_ok;
      assign unused_ok = clk ^ rst_n ^ rd;
      assign rdata = sel;
   end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 6,
   parameter int DESC_W   = 32,
   parameter bit READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              eng_enable,
   output logic              eng_append_req,
   input  logic              eng_append_ack,
   input  logic              eng_busy,
   input  logic [DESC_W-1:0] eng_cur_desc,
   output logic [DESC_W-1:0] eng_next_desc,
   input  logic              evt_xfer_done,
   input  logic              evt_chain_end,
   input  logic [3:0]        evt_fault,
   output logic              irq
);
   import dma_regs_pkg::*;

   localparam int MIN_DATA_W = BIT_BUSY + 1;
   localparam int MIN_ADDR_W = $clog2(OFS_NEXT + 1);

   initial begin
      if (DATA_W < MIN_DATA_W) $error("DATA_W too narrow for status layout");
      if (ADDR_W < MIN_ADDR_W) $error("ADDR_W too narrow for register offsets");
      if (DESC_W > DATA_W)     $error("DESC_W must not exceed DATA_W");
   end

   logic wr_ctrl, wr_stat, wr_next;
   assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
   assign wr_stat = reg_wr && (reg_addr == ADDR_W'(OFS_STAT));
   assign wr_next = reg_wr && (reg_addr == ADDR_W'(OFS_NEXT));

   // control
   ctrl_t ctrl;
   dma_ctrl_reg u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctrl   (wr_ctrl),
      .wdata_en  (reg_wdata[BIT_ENABLE]),
      .wdata_app (reg_wdata[BIT_APPEND]),
      .app_ack   (eng_append_ack),
      .ctrl      (ctrl)
   );
   assign eng_enable     = ctrl.enable;
   assign eng_append_req = ctrl.append;

   // sticky status
   logic [STICKY_N-1:0] evt_vec, clr_vec, flags;
   assign evt_vec = {evt_fault, evt_chain_end, evt_xfer_done};

   always_comb begin
      for (int i = 0; i < STICKY_N; i++)
         clr_vec[i] = wr_stat & reg_wdata[sticky_pos(i)];
   end

   dma_sticky_status #(.N(STICKY_N)) u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt_vec),
      .clr   (clr_vec),
      .flags (flags)
   );

   // next-descriptor pointer
   logic [DESC_W-1:0] next_q;
   always_ff @(posedge clk) begin
      if (!rst_n)
         next_q <= '0;
      else if (wr_next)
         next_q <= reg_wdata[DESC_W-1:0];
   end
   assign eng_next_desc = next_q;

   // readback words
   logic [DATA_W-1:0] ctrl_word, stat_word;
   always_comb begin
      ctrl_word             = '0;
      ctrl_word[BIT_ENABLE] = ctrl.enable;
      ctrl_word[BIT_APPEND] = ctrl.append;
      stat_word             = '0;
      stat_word[BIT_BUSY]   = eng_busy;
      for (int i = 0; i < STICKY_N; i++)
         stat_word[sticky_pos(i)] = flags[i];
   end

   dma_read_mux #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .DESC_W   (DESC_W),
      .READ_REG (READ_REG)
   ) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd        (reg_rd),
      .addr      (reg_addr),
      .ctrl_word (ctrl_word),
      .stat_word (stat_word),
      .cur_desc  (eng_cur_desc),
      .next_desc (next_q),
      .rdata     (reg_rdata)
   );

   assign irq = |flags;

   p_next_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_next |=> eng_next_desc == $past(reg_wdata[DESC_W-1:0]));
   p_next_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_next |=> $stable(eng_next_desc));
   p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(|evt_vec));
   p_irq_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(wr_stat));
endmodule

// File: tb/sim_dma_chan_regs.sv
module sim_dma_chan_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        eng_enable, eng_append_req;
   logic        eng_append_ack = 1'b0, eng_busy = 1'b0;
   logic [31:0] eng_cur_desc = '0;
   logic [31:0] eng_next_desc;
   logic        evt_xfer_done = 1'b0, evt_chain_end = 1'b0;
   logic [3:0]  evt_fault = '0;
   logic        irq;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dma_chan_regs u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .eng_enable(eng_enable), .eng_append_req(eng_append_req),
      .eng_append_ack(eng_append_ack), .eng_busy(eng_busy),
      .eng_cur_desc(eng_cur_desc), .eng_next_desc(eng_next_desc),
      .evt_xfer_done(evt_xfer_done), .evt_chain_end(evt_chain_end),
      .evt_fault(evt_fault), .irq(irq)
   );

   // reference model state
   logic        m_en = 0, m_app = 0;
   logic [31:0] m_stat = '0, m_next = '0;

   function automatic int pos_of(input int i);
      case (i)
         0: return 12; 1: return 11; 2: return 3;
         3: return 4;  4: return 5;  default: return 9;
      endcase
   endfunction

   function automatic logic [31:0] model_read(input logic [5:0] a, input logic busy,
                                             input logic [31:0] cur);
      case (a)
         6'h00:   return {30'd0, m_app, m_en};
         6'h04:   return m_stat | (32'(busy) << 13);
         6'h08:   return cur;
         6'h24:   return m_next;
         default: return 32'd0;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one clock: drive at negedge, advance model, check at next negedge
   task automatic step(input logic wr, input logic rd, input logic [5:0] a,
                       input logic [31:0] wd, input logic ack, input logic busy,
                       input logic [31:0] cur, input logic [5:0] ev, input string tag);
      logic [31:0] exp_rd;
      reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
      eng_append_ack = ack; eng_busy = busy; eng_cur_desc = cur;
      evt_xfer_done = ev[0]; evt_chain_end = ev[1]; evt_fault = ev[5:2];
      exp_rd = model_read(a, busy, cur);
      for (int i = 0; i < 6; i++) begin
         if (ev[i]) m_stat[pos_of(i)] = 1'b1;
         else if (wr && a == 6'h04 && wd[pos_of(i)]) m_stat[pos_of(i)] = 1'b0;
      end
      if (wr && a == 6'h00) begin
         m_en = wd[0];
         if (wd[1]) m_app = 1'b1;
         else if (ack) m_app = 1'b0;
      end else if (ack) m_app = 1'b0;
      if (wr && a == 6'h24) m_next = wd;
      @(posedge clk);
      @(negedge clk);
      check({tag, " R2 enable"}, 32'(eng_enable), 32'(m_en));
      check({tag, " R3 append"}, 32'(eng_append_req), 32'(m_app));
      check({tag, " R9 next"}, eng_next_desc, m_next);
      check({tag, " R10 irq"}, 32'(irq), 32'(|m_stat));
      if (rd) check({tag, " R11 rdata"}, reg_rdata, exp_rd);
   endtask

   task automatic idle(input string tag);
      step(0, 0, 6'h00, 0, 0, 0, 0, 6'd0, tag);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 rdata", reg_rdata, 0);
      check("R1 enable", 32'(eng_enable), 0);
      check("R1 append", 32'(eng_append_req), 0);
      check("R1 next", eng_next_desc, 0);
      check("R1 irq", 32'(irq), 0);
      step(0, 1, 6'h04, 0, 0, 0, 0, 0, "R1 status");

      // R2 / R3 directed
      step(1, 0, 6'h00, 32'h3, 0, 0, 0, 0, "R2 R3 set");
      step(1, 1, 6'h00, 32'h1, 0, 0, 0, 0, "R3 write0 no effect");
      step(0, 1, 6'h00, 0, 0, 0, 0, 0, "R3 readback");
      step(1, 0, 6'h00, 32'h3, 1, 0, 0, 0, "R3 ack vs set");
      step(0, 0, 6'h00, 0, 1, 0, 0, 0, "R3 ack clears");
      step(0, 1, 6'h00, 0, 0, 0, 0, 0, "R3 cleared");
      step(1, 0, 6'h00, 32'h0, 0, 0, 0, 0, "R2 disable");

      // R4 busy, write ignored
      step(1, 1, 6'h04, 32'h2000, 0, 1, 0, 0, "R4 busy high");
      step(0, 1, 6'h04, 0, 0, 0, 0, 0, "R4 busy low");

      // R5 / R6 / R7 sticky flags
      step(0, 0, 6'h00, 0, 0, 0, 0, 6'b111111, "R5 R6 set all");
      step(1, 1, 6'h04, 32'h0, 0, 0, 0, 0, "R5 write0 keeps");
      step(0, 1, 6'h04, 0, 0, 0, 0, 0, "R6 all flags 0x1a38");
      check("R6 flag positions", reg_rdata, 32'h1a38);
      step(1, 0, 6'h04, 32'h1000, 0, 0, 0, 6'b000001, "R7 event vs clear");
      step(1, 1, 6'h04, 32'h0238, 0, 0, 0, 0, "R6 clear faults");
      step(0, 1, 6'h04, 0, 0, 0, 0, 0, "R5 only done+chain");
      check("R5 remaining", reg_rdata, 32'h1800);
      step(1, 0, 6'h04, 32'hffff_ffff, 0, 0, 0, 0, "R10 irq drop");

      // R8 / R9 / R11
      step(1, 0, 6'h08, 32'hdead_beef, 0, 0, 32'h1234_5670, 0, "R8 write ignored");
      step(0, 1, 6'h08, 0, 0, 0, 32'h1234_5670, 0, "R8 cur desc");
      step(1, 0, 6'h24, 32'h0bad_f00c, 0, 0, 0, 0, "R9 write");
      step(1, 1, 6'h30, 32'hffff_ffff, 0, 0, 0, 0, "R11 unmapped");
      step(0, 1, 6'h24, 0, 0, 0, 0, 0, "R9 readback");
      idle("R11 hold");
      check("R11 rdata hold", reg_rdata, 32'h0bad_f00c);

      // constrained random
      for (int n = 0; n < 3000; n++) begin
         logic [5:0] a;
         int k;
         logic [5:0] ev;
         logic ack;
         k = int'($urandom % 5);
         a = (k == 0) ? 6'h00 : (k == 1) ? 6'h04 : (k == 2) ? 6'h08 :
             (k == 3) ? 6'h24 : 6'($urandom);
         for (int i = 0; i < 6; i++) ev[i] = ($urandom % 8) == 0;
         ack = m_app ? (($urandom % 3) == 0) : (($urandom % 16) == 0);
         step(($urandom % 3) == 0, ($urandom % 2) == 0, a, $urandom, ack,
              1'($urandom), $urandom, ev, "random");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule